// File: doc/BRIEF.md
# Power-On Reset Sequencer with Reset-Cause Register

This block turns a digital "supply good" indication from a voltage comparator into a held, active-low system reset. While the supply is low, reset stays asserted. Once the supply is good, reset is stretched for a programmable number of clock cycles before release. The comparator input is assumed to be synchronous to `clk` and already debounced. The block therefore has no separate reset input: a low `supply_ok` is itself the cold reset.

While the system runs, the block also accepts other reset causes: an external reset request and a vector of internal cause pulses (for example watchdog, software request and missing clock). Each of these produces a shorter, fixed-length reset pulse. A read-only cause register records why the last reset happened, so software can tell a cold power-up from a warm restart. All causes restart execution at the same constant address, which is output on `restart_vec`. A supply-monitor enable bit is forced on by every power-up. Software may change it only while the system is out of reset.

All pins are plain control and status signals. No data stream passes through the block, so there is no handshake.

Top module: `rst_seq_top`

## Requirements
- R1: While `supply_ok` is low at a rising clock edge, `rst_n` is low after that edge and stays low for as long as `supply_ok` stays low.
- R2: After `supply_ok` goes high, `rst_n` rises after exactly POR_CYCLES consecutive rising edges at which `supply_ok` was high.
- R3: When the power-on sequence ends, bit 1 of `src_flags` (the power-up flag) reads 1 and `mon_en` reads 1. While bit 1 is set, the other bits of `src_flags` carry no meaning.
- R4: Any non-power reset clears bit 1 of `src_flags`.
- R5: A non-power reset sets exactly one cause bit and clears all others. Bit 0 is `ext_rst_req` and bit 2+i is `cause_req[i]`. When several requests arrive in the same cycle, the lowest bit position wins.
- R6: A non-power reset drives `rst_n` low for exactly PULSE_CYCLES cycles. Requests that arrive while `rst_n` is low are ignored.
- R7: `restart_vec` always equals RESTART_ADDR (default 0x0000), whatever the reset cause.
- R8: If `supply_ok` drops during the stretch count or during normal running, the count restarts from zero and a complete power-on sequence follows.
- R9: A write to `mon_en` (`mon_wr` high, value `mon_wdata`) takes effect only when `rst_n` is high. While reset is asserted the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| supply_ok | input | 1 | Synchronous supply-above-threshold indication; low forces a cold reset |
| ext_rst_req | input | 1 | External reset request, one-cycle pulse |
| cause_req | input | N_CAUSE | Internal reset-cause pulses, one bit per cause |
| mon_wr | input | 1 | Write strobe for the supply-monitor enable |
| mon_wdata | input | 1 | Value written to the supply-monitor enable |
| rst_n | output | 1 | Active-low system reset |
| restart_vec | output | VEC_W | Constant restart address |
| mon_en | output | 1 | Supply-monitor enable |
| src_flags | output | N_CAUSE+2 | Reset-cause register, read-only |

## Verification
The hardest cases to reach are a supply drop that lands while the block is busy with something else: part-way through the stretch count, or in the middle of a running system whose cause register currently holds a warm-reset cause. The stimulus raises `supply_ok` for only part of the stretch, drops it, and raises it again. This checks that the count starts over and does not resume. It also removes the supply after a warm reset has cleared the power-up flag and `mon_en` has been written to 0. This checks that both are restored. Requests and monitor writes are also issued inside a warm-reset pulse to show that they leave no trace.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_RUN   = 2'd1,
    ST_PULSE = 2'd2
  } seq_state_e;

  // Cause register bit positions (software decodes these)
  localparam int EXT_BIT    = 0;
  localparam int POR_BIT    = 1;
  localparam int CAUSE_BASE = 2;

endpackage

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int POR_CYCLES   = 30000,
  parameter int PULSE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       supply_ok,
  input  logic       any_req,
  output seq_state_e state_o,
  output logic       rst_n
);

  localparam int MAXC  = (POR_CYCLES > PULSE_CYCLES) ? POR_CYCLES : PULSE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYCLES - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  // Supply low acts as the cold reset of this block
  always_ff @(posedge clk) begin
    if (!supply_ok) begin
      state_q <= ST_POR;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_POR: begin
          if (cnt_q == POR_LAST) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (any_req) begin
            state_q <= ST_PULSE;
            cnt_q   <= '0;
          end
        end
        ST_PULSE: begin
          if (cnt_q == PULSE_LAST) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_POR;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign state_o = state_q;
  assign rst_n   = (state_q == ST_RUN);

  // R1: a returning supply always finds reset held
  a_r1_held_on_return: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(supply_ok) |-> !rst_n);

  // R2: no release before the stretch count is complete
  a_r2_no_early_release: assert property (@(posedge clk) disable iff (!supply_ok)
    (state_q == ST_POR && cnt_q != POR_LAST) |=> !rst_n);

  // R6: a warm pulse ends only after its full length
  a_r6_pulse_length: assert property (@(posedge clk) disable iff (!supply_ok)
    ($past(state_q) == ST_PULSE && rst_n) |-> $past(cnt_q) == PULSE_LAST);

endmodule

// File: rtl/rst_seq_flags.sv
module rst_seq_flags
  import rst_seq_pkg::*;
#(
  parameter int N_CAUSE = 3,
  localparam int SRC_W  = N_CAUSE + CAUSE_BASE
) (
  input  logic             clk,
  input  logic             supply_ok,
  input  seq_state_e       state_i,
  input  logic             ext_req,
  input  logic [N_CAUSE-1:0] cause_req,
  input  logic             mon_wr,
  input  logic             mon_wdata,
  output logic             any_req,
  output logic [SRC_W-1:0] src_flags,
  output logic             mon_en
);

  logic [SRC_W-1:0] req_vec;
  logic [SRC_W-1:0] winner;
  logic [SRC_W-1:0] src_q;
  logic             mon_q;
  logic             take;
  logic             power_up;

  assign req_vec[EXT_BIT] = ext_req;
  assign req_vec[POR_BIT] = 1'b0;
  for (genvar g = 0; g < N_CAUSE; g++) begin : g_cause_map
    assign req_vec[CAUSE_BASE + g] = cause_req[g];
  end

  // Lowest set position wins
  assign winner   = req_vec & (~req_vec + 1'b1);
  assign any_req  = |req_vec;
  assign take     = supply_ok && (state_i == ST_RUN) && any_req;
  assign power_up = !supply_ok || (state_i == ST_POR);

  always_ff @(posedge clk) begin
    if (power_up) begin
      src_q[POR_BIT] <= 1'b1;
      mon_q          <= 1'b1;
    end else if (take) begin
      src_q <= winner;
    end else if (state_i == ST_RUN && mon_wr) begin
      mon_q <= mon_wdata;
    end
  end

  assign src_flags = src_q;
  assign mon_en    = mon_q;

  // R3: leaving power-up shows the flag and an enabled monitor
  a_r3_flag_on_release: assert property (@(posedge clk) disable iff (!supply_ok)
    ($past(state_i) == ST_POR && state_i == ST_RUN) |-> (src_q[POR_BIT] && mon_q));

  // R4/R5: a warm cause leaves exactly one bit, never the power-up flag
  a_r5_single_cause: assert property (@(posedge clk) disable iff (!supply_ok)
    take |=> ($countones(src_q) == 1 && !src_q[POR_BIT]));

  // R9: no monitor change inside a warm pulse
  a_r9_mon_frozen: assert property (@(posedge clk) disable iff (!supply_ok)
    (state_i == ST_PULSE) |=> $stable(mon_q));

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int POR_CYCLES   = 30000,
  parameter int PULSE_CYCLES = 8,
  parameter int N_CAUSE      = 3,
  parameter int VEC_W        = 16,
  parameter logic [VEC_W-1:0] RESTART_ADDR = '0
) (
  input  logic                    clk,
  input  logic                    supply_ok,
  input  logic                    ext_rst_req,
  input  logic [N_CAUSE-1:0]      cause_req,
  input  logic                    mon_wr,
  input  logic                    mon_wdata,
  output logic                    rst_n,
  output logic [VEC_W-1:0]        restart_vec,
  output logic                    mon_en,
  output logic [N_CAUSE+CAUSE_BASE-1:0] src_flags
);

  seq_state_e state;
  logic       any_req;

  rst_seq_fsm #(
    .POR_CYCLES  (POR_CYCLES),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .supply_ok(supply_ok),
    .any_req  (any_req),
    .state_o  (state),
    .rst_n    (rst_n)
  );

  rst_seq_flags #(
    .N_CAUSE(N_CAUSE)
  ) u_flags (
    .clk      (clk),
    .supply_ok(supply_ok),
    .state_i  (state),
    .ext_req  (ext_rst_req),
    .cause_req(cause_req),
    .mon_wr   (mon_wr),
    .mon_wdata(mon_wdata),
    .any_req  (any_req),
    .src_flags(src_flags),
    .mon_en   (mon_en)
  );

  assign restart_vec = RESTART_ADDR;

  // R7: the restart address never moves across a reset
  a_r7_vector_steady: assert property (@(posedge clk) disable iff (!supply_ok)
    $fell(rst_n) |=> $stable(restart_vec));

endmodule

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;

  localparam int POR_C   = 20;
  localparam int PULSE_C = 5;
  localparam int NC      = 3;
  localparam int VW      = 16;
  localparam int SW      = NC + 2;

  logic          clk = 1'b0;
  logic          supply_ok = 1'b0;
  logic          ext_rst_req = 1'b0;
  logic [NC-1:0] cause_req = '0;
  logic          mon_wr = 1'b0;
  logic          mon_wdata = 1'b0;
  logic          rst_n;
  logic [VW-1:0] restart_vec;
  logic          mon_en;
  logic [SW-1:0] src_flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  rst_seq_top #(
    .POR_CYCLES(POR_C), .PULSE_CYCLES(PULSE_C), .N_CAUSE(NC), .VEC_W(VW)
  ) dut_i (
    .clk(clk), .supply_ok(supply_ok), .ext_rst_req(ext_rst_req),
    .cause_req(cause_req), .mon_wr(mon_wr), .mon_wdata(mon_wdata),
    .rst_n(rst_n), .restart_vec(restart_vec), .mon_en(mon_en),
    .src_flags(src_flags)
  );

  // Behavioural reference: 0 = cold, 1 = running, 2 = warm pulse
  int            m_mode = 0;
  int            m_hi = 0;
  int            m_left = 0;
  logic [SW-1:0] m_src = '0;
  logic          m_mon = 1'b1;

  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (!supply_ok) begin
      m_mode = 0; m_hi = 0; m_src[1] = 1'b1; m_mon = 1'b1;
    end else if (m_mode == 0) begin
      m_hi++; m_src[1] = 1'b1; m_mon = 1'b1;
      if (m_hi == POR_C) m_mode = 1;
    end else if (m_mode == 1) begin
      if (ext_rst_req || cause_req != 0) begin
        m_mode = 2; m_left = PULSE_C;
        m_src = '0;
        if (ext_rst_req) m_src[0] = 1'b1;
        else begin
          for (int i = NC - 1; i >= 0; i--) if (cause_req[i]) begin
            m_src = '0; m_src[2 + i] = 1'b1;
          end
        end
      end else if (mon_wr) m_mon = mon_wdata;
    end else begin
      m_left--;
      if (m_left == 0) m_mode = 1;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s): actual %0h expected %0h at cycle %0d", phase, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("rst_n R1/R2/R6", 32'(rst_n), 32'(m_mode == 1));
    chk("restart_vec R7", 32'(restart_vec), 32'h0);
    chk("mon_en R3/R9", 32'(mon_en), 32'(m_mon));
    chk("power-up flag R3/R4", 32'(src_flags[1]), 32'(m_src[1]));
    if (!m_src[1]) chk("cause bits R5", 32'(src_flags), 32'(m_src));
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(input logic ext, input logic [NC-1:0] c);
    @(negedge clk);
    ext_rst_req = ext; cause_req = c;
    @(negedge clk);
    ext_rst_req = 1'b0; cause_req = '0;
  endtask

  task automatic write_mon(input logic v);
    @(negedge clk);
    mon_wr = 1'b1; mon_wdata = v;
    @(negedge clk);
    mon_wr = 1'b0;
  endtask

  initial begin
    phase = "R1"; idle(6);
    phase = "R8"; supply_ok = 1'b1; idle(10);
    supply_ok = 1'b0; idle(2);
    phase = "R2"; supply_ok = 1'b1; idle(POR_C + 4);
    phase = "R3"; idle(2);
    phase = "R9"; write_mon(1'b0); idle(2);
    phase = "R5"; pulse_req(1'b1, '0); idle(PULSE_C + 2);
    phase = "R4"; pulse_req(1'b0, 3'b001); idle(PULSE_C + 2);
    phase = "R5"; pulse_req(1'b0, 3'b110); idle(PULSE_C + 2);
    pulse_req(1'b1, 3'b100); idle(PULSE_C + 2);
    pulse_req(1'b0, 3'b100); idle(1);
    phase = "R6"; pulse_req(1'b0, 3'b010); idle(1);
    pulse_req(1'b1, '0); idle(PULSE_C + 2);
    phase = "R9"; pulse_req(1'b0, 3'b001); write_mon(1'b1); idle(PULSE_C + 2);
    write_mon(1'b1); write_mon(1'b0); idle(2);
    phase = "R8"; supply_ok = 1'b0; idle(3);
    supply_ok = 1'b1; idle(POR_C + 3);
    phase = "R7"; pulse_req(1'b0, 3'b100); idle(PULSE_C + 3);
    phase = "R4"; idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule